// File: doc/BRIEF.md
# Next-PC Select and Instruction Kill Control

This block steers the front of a five-stage in-order pipeline. Unconditional jumps are recognised in the decode stage and conditional branches on zero or non-zero are resolved in the execute stage. From the opcode in decode, the opcode in execute, the zero flag of the execute operand and the hazard unit's stall line, it produces the select for the program-counter source multiplexer. The four sources are the sequential address, an absolute jump target, a register-indirect target and a branch target. It also produces a hold enable for the PC.

The block holds the decode-stage and execute-stage instruction registers itself. Each clock it loads them with a fetched word, keeps them as they are, or puts a nop in their place. A taken branch removes the two younger instructions behind it. A jump removes the single instruction fetched behind it. When a taken branch in execute and a jump in decode are present together, the older instruction in execute wins. Target arithmetic and hazard detection are done elsewhere.

The opcode is the top six bits of the instruction, [31:26]. The codes are: J = 6'h02, JAL = 6'h03, BEQZ = 6'h04, BNEZ = 6'h05, JR = 6'h06, JALR = 6'h07. The nop is the all-zero word. The PC select is coded 0 = sequential, 1 = absolute jump, 2 = register-indirect, 3 = branch.

Top module: `npc_kill_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it is released, both instruction registers (decInstr, exeInstr) hold the all-zero nop.
- R2: When exeInstr has opcode 6'h04 (BEQZ) and exeZero is 1, or has opcode 6'h05 (BNEZ) and exeZero is 0, the branch is taken. pcSel is then 3 whatever decInstr holds.
- R3: A BEQZ with exeZero 0 or a BNEZ with exeZero 1 in execute is not taken. It has no effect on pcSel, pcHold or the register updates.
- R4: With no taken branch, pcSel is 1 for decode opcode 6'h02 or 6'h03, 2 for 6'h06 or 6'h07, and 0 for any other opcode.
- R5: After a clock edge with a taken branch, both decInstr and exeInstr are nop and pcHold was 0, even with stall high. This gives two bubbles.
- R6: After a clock edge with no taken branch, no stall and one of the four jump opcodes in decode, decInstr is nop and exeInstr holds the jump. This gives one bubble.
- R7: With stall high and no taken branch, pcHold is 1. After the edge decInstr keeps its value and exeInstr is nop.
- R8: With no taken branch, no stall and no jump in decode, pcHold is 0. After the edge decInstr takes imemInstr and exeInstr takes the previous decInstr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imemInstr | input | 32 | Instruction word from instruction memory |
| exeZero | input | 1 | Zero flag of the execute-stage branch operand |
| stall | input | 1 | Stall request from the hazard detector |
| pcSel | output | 2 | PC source select (0 seq, 1 abs jump, 2 reg-indirect, 3 branch) |
| pcHold | output | 1 | PC keeps its value this cycle |
| decInstr | output | 32 | Decode-stage instruction register |
| exeInstr | output | 32 | Execute-stage instruction register |

## Verification
The hardest case to reach is a taken branch in execute at the same moment as a jump in decode, ideally with stall high as well. A branch can only reach execute after it passes through decode without a stall. The word fetched right behind it must be a jump. The stall line must be high on exactly the cycle the two meet. The random stimulus gives control-flow opcodes heavy weight so that branch-then-jump pairs happen often. A directed sequence then builds the branch-and-jump pair with stall raised, and again with each input dropped in turn.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_J    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JAL  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQZ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNEZ = 6'h05;
  localparam logic [OPC_W-1:0] OPC_JR   = 6'h06;
  localparam logic [OPC_W-1:0] OPC_JALR = 6'h07;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_JABS   = 2'd1,
    PC_RIND   = 2'd2,
    PC_BRANCH = 2'd3
  } pcSrcE;

  typedef enum logic [1:0] {
    DEC_LOAD = 2'd0,
    DEC_HOLD = 2'd1,
    DEC_NOP  = 2'd2
  } decSrcE;

  // strobes from control to datapath
  typedef struct packed {
    decSrcE decSrc;
    logic   exeNop;
  } strobeS;

  // opcode class flags
  typedef struct packed {
    logic jAbs;
    logic jReg;
    logic brEqz;
    logic brNez;
  } opClassS;

  function automatic logic branchTaken(input logic [OPC_W-1:0] op, input logic zero);
    return ((op == OPC_BEQZ) && zero) || ((op == OPC_BNEZ) && !zero);
  endfunction

  function automatic logic anyJump(input logic [OPC_W-1:0] op);
    return (op == OPC_J) || (op == OPC_JAL) || (op == OPC_JR) || (op == OPC_JALR);
  endfunction
endpackage

// File: rtl/npc_opclass.sv
module npc_opclass
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opClassS          cls
);
  always_comb begin
    cls       = '0;
    cls.jAbs  = (opcode == OPC_J)  || (opcode == OPC_JAL);
    cls.jReg  = (opcode == OPC_JR) || (opcode == OPC_JALR);
    cls.brEqz = (opcode == OPC_BEQZ);
    cls.brNez = (opcode == OPC_BNEZ);
  end
endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
#(
  parameter int STAGES = 2
)(
  input  logic [STAGES-1:0][OPC_W-1:0] stageOp,  // [0] decode, [1] execute
  input  logic                         exeZero,
  input  logic                         stall,
  output pcSrcE                        pcSel,
  output logic                         pcHold,
  output strobeS                       strobe
);
  localparam int DEC = 0;
  localparam int EXE = 1;

  opClassS cls [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_cls
    npc_opclass u_cls (.opcode(stageOp[s]), .cls(cls[s]));
  end

  logic taken;
  logic decJump;

  assign taken   = (cls[EXE].brEqz && exeZero) || (cls[EXE].brNez && !exeZero);
  assign decJump = cls[DEC].jAbs || cls[DEC].jReg;

  // older instruction (execute) first, then decode
  always_comb begin
    if (taken)               pcSel = PC_BRANCH;
    else if (cls[DEC].jAbs)  pcSel = PC_JABS;
    else if (cls[DEC].jReg)  pcSel = PC_RIND;
    else                     pcSel = PC_SEQ;
  end

  always_comb begin
    strobe = '0;
    pcHold = 1'b0;
    if (taken) begin
      strobe.decSrc = DEC_NOP;
      strobe.exeNop = 1'b1;
    end else if (stall) begin
      strobe.decSrc = DEC_HOLD;
      strobe.exeNop = 1'b1;
      pcHold        = 1'b1;
    end else if (decJump) begin
      strobe.decSrc = DEC_NOP;
      strobe.exeNop = 1'b0;
    end else begin
      strobe.decSrc = DEC_LOAD;
      strobe.exeNop = 1'b0;
    end
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int INSTR_W = 32
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] imemInstr,
  input  strobeS             strobe,
  output logic [INSTR_W-1:0] decInstr,
  output logic [INSTR_W-1:0] exeInstr,
  output logic [OPC_W-1:0]   decOp,
  output logic [OPC_W-1:0]   exeOp
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  logic [INSTR_W-1:0] decNext;
  logic [INSTR_W-1:0] exeNext;

  always_comb begin
    unique case (strobe.decSrc)
      DEC_HOLD: decNext = decInstr;
      DEC_NOP:  decNext = NOP_WORD;
      default:  decNext = imemInstr;
    endcase
    exeNext = strobe.exeNop ? NOP_WORD : decInstr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decInstr <= NOP_WORD;
      exeInstr <= NOP_WORD;
    end else begin
      decInstr <= decNext;
      exeInstr <= exeNext;
    end
  end

  assign decOp = decInstr[INSTR_W-1:OPC_LSB];
  assign exeOp = exeInstr[INSTR_W-1:OPC_LSB];
endmodule

// File: rtl/npc_kill_ctrl.sv
module npc_kill_ctrl
  import npc_pkg::*;
#(
  parameter int INSTR_W = 32
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] imemInstr,
  input  logic               exeZero,
  input  logic               stall,
  output logic [1:0]         pcSel,
  output logic               pcHold,
  output logic [INSTR_W-1:0] decInstr,
  output logic [INSTR_W-1:0] exeInstr
);
  strobeS              strobe;
  pcSrcE               pcSrc;
  logic [OPC_W-1:0]    decOp;
  logic [OPC_W-1:0]    exeOp;
  logic [1:0][OPC_W-1:0] stageOp;

  assign stageOp[0] = decOp;
  assign stageOp[1] = exeOp;

  npc_datapath #(.INSTR_W(INSTR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .imemInstr(imemInstr),
    .strobe   (strobe),
    .decInstr (decInstr),
    .exeInstr (exeInstr),
    .decOp    (decOp),
    .exeOp    (exeOp)
  );

  npc_ctrl #(.STAGES(2)) u_ctrl (
    .stageOp(stageOp),
    .exeZero(exeZero),
    .stall  (stall),
    .pcSel  (pcSrc),
    .pcHold (pcHold),
    .strobe (strobe)
  );

  assign pcSel = pcSrc;
endmodule

// File: rtl/npc_kill_ctrl_chk.sv
module npc_kill_ctrl_chk
  import npc_pkg::*;
#(
  parameter int INSTR_W = 32
)(
  input logic               clk,
  input logic               rstN,
  input logic               exeZero,
  input logic               stall,
  input logic [1:0]         pcSel,
  input logic               pcHold,
  input logic [INSTR_W-1:0] decInstr,
  input logic [INSTR_W-1:0] exeInstr
);
  localparam int LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] dOp;
  logic [OPC_W-1:0] eOp;
  logic             tk;

  assign dOp = decInstr[INSTR_W-1:LSB];
  assign eOp = exeInstr[INSTR_W-1:LSB];
  assign tk  = branchTaken(eOp, exeZero);

  AST_TAKEN_SEL: assert property (@(posedge clk) disable iff (!rstN)
    tk |-> pcSel == 2'd3);  // R2
  AST_TAKEN_KILL: assert property (@(posedge clk) disable iff (!rstN)
    tk |=> (decInstr == '0) && (exeInstr == '0));  // R5
  AST_TAKEN_NOHOLD: assert property (@(posedge clk) disable iff (!rstN)
    tk |-> !pcHold);  // R5
  AST_JUMP_ABS: assert property (@(posedge clk) disable iff (!rstN)
    (!tk && (dOp == OPC_J || dOp == OPC_JAL)) |-> pcSel == 2'd1);  // R4
  AST_JUMP_REG: assert property (@(posedge clk) disable iff (!rstN)
    (!tk && (dOp == OPC_JR || dOp == OPC_JALR)) |-> pcSel == 2'd2);  // R4
  AST_JUMP_KILL: assert property (@(posedge clk) disable iff (!rstN)
    (!tk && !stall && anyJump(dOp)) |=> decInstr == '0);  // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tk && stall) |=> $stable(decInstr) && (exeInstr == '0));  // R7
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> stall);  // R7
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!tk && !stall) |=> exeInstr == $past(decInstr));  // R8
endmodule

bind npc_kill_ctrl npc_kill_ctrl_chk #(.INSTR_W(INSTR_W)) chk_i (
  .clk(clk), .rstN(rstN), .exeZero(exeZero), .stall(stall),
  .pcSel(pcSel), .pcHold(pcHold), .decInstr(decInstr), .exeInstr(exeInstr)
);

// File: tb/npc_kill_ctrl_tb_top.sv
module npc_kill_ctrl_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] imemInstr = '0;
  logic         exeZero = 1'b0;
  logic         stall = 1'b0;
  logic [1:0]   pcSel;
  logic         pcHold;
  logic [W-1:0] decInstr;
  logic [W-1:0] exeInstr;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] decM = '0;
  logic [W-1:0] exeM = '0;

  always #4 clk = ~clk;

  npc_kill_ctrl #(.INSTR_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .imemInstr(imemInstr), .exeZero(exeZero),
    .stall(stall), .pcSel(pcSel), .pcHold(pcHold),
    .decInstr(decInstr), .exeInstr(exeInstr)
  );

  function automatic logic [5:0] op(input logic [W-1:0] i);
    return i[W-1:W-6];
  endfunction

  function automatic logic isTaken(input logic [W-1:0] e, input logic z);
    return (op(e) == 6'h04 && z) || (op(e) == 6'h05 && !z);
  endfunction

  function automatic logic isJump(input logic [W-1:0] d);
    return op(d) >= 6'h02 && op(d) <= 6'h07 && op(d) != 6'h04 && op(d) != 6'h05;
  endfunction

  function automatic logic [1:0] expSel(input logic [W-1:0] d, input logic [W-1:0] e, input logic z);
    if (isTaken(e, z)) return 2'd3;
    if (op(d) == 6'h02 || op(d) == 6'h03) return 2'd1;
    if (op(d) == 6'h06 || op(d) == 6'h07) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [W-1:0] mkInstr(input logic [5:0] o);
    return {o, 26'($urandom)};
  endfunction

  function automatic logic [W-1:0] rndInstr();
    int unsigned r = $urandom_range(0, 9);
    case (r)
      0: return '0;
      1, 2: return mkInstr(6'($urandom_range(8, 63)));
      default: return mkInstr(6'($urandom_range(2, 7)));
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive inputs at negedge, check outputs, advance model
  task automatic step(input logic [W-1:0] im, input logic z, input logic st);
    string tg;
    logic tk;
    imemInstr = im; exeZero = z; stall = st;
    #1;
    tk = isTaken(exeM, z);
    if (tk) tg = "R2";
    else if (op(exeM) == 6'h04 || op(exeM) == 6'h05) tg = "R3";
    else tg = "R4";
    check(tg, W'(pcSel), W'(expSel(decM, exeM, z)));
    check(tk ? "R5" : (st ? "R7" : "R8"), W'(pcHold), W'(!tk && st));
    if (tk) begin
      exeM = '0; decM = '0; tg = "R5";
    end else if (st) begin
      exeM = '0; tg = "R7";
    end else if (isJump(decM)) begin
      exeM = decM; decM = '0; tg = "R6";
    end else begin
      exeM = decM; decM = im; tg = "R8";
    end
    @(negedge clk);
    check(tg, decInstr, decM);
    check(tg, exeInstr, exeM);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250601));
    repeat (3) @(negedge clk);
    check("R1", decInstr, '0);
    check("R1", exeInstr, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", decInstr, '0);
    check("R1", exeInstr, '0);

    // directed: branch in exe with jump in decode, stall high (R2, R5)
    step(mkInstr(6'h04), 1'b0, 1'b0);
    step(mkInstr(6'h02), 1'b0, 1'b0);
    step(mkInstr(6'h09), 1'b1, 1'b1);
    // BNEZ not taken with JR behind it (R3, R4, R6)
    step(mkInstr(6'h05), 1'b0, 1'b0);
    step(mkInstr(6'h06), 1'b0, 1'b0);
    step(mkInstr(6'h11), 1'b1, 1'b0);
    step(mkInstr(6'h12), 1'b0, 1'b0);
    // jump in decode held by stall (R7)
    step(mkInstr(6'h03), 1'b0, 1'b0);
    step(mkInstr(6'h20), 1'b0, 1'b1);
    step(mkInstr(6'h21), 1'b0, 1'b1);
    step(mkInstr(6'h22), 1'b0, 1'b0);
    // taken BNEZ, stall low (R5)
    step(mkInstr(6'h05), 1'b0, 1'b0);
    step(mkInstr(6'h07), 1'b0, 1'b0);
    step(mkInstr(6'h13), 1'b0, 1'b0);

    for (int i = 0; i < 4000; i++)
      step(rndInstr(), 1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule